// File: doc/BRIEF.md
# Hiccup Overload Supervisor

This block sits beside the control loop of a switching converter. It enforces a hiccup shutdown when the converter stays in overload. The block sees one strobe per PWM cycle and a flag that says whether the cycle-by-cycle current limit tripped during that cycle. It also sees whether the soft-start ramp has completed. It does not count overloaded cycles until soft-start is done. The count accumulates even when the overloaded cycles are interleaved with clean ones. Only an unbroken run of clean cycles wipes it.

When the count reaches its limit, the supervisor stops switching and asks the soft-start node to be discharged. It then waits a long, cycle-counted off period before it lets the converter restart. At the restart the discharge request is released, so a fresh soft-start ramp begins. Counting resumes only after that ramp reports completion.

The defaults are a limit of 64 overloaded cycles, a clean run of 8 cycles and an off period of 32,768 cycles. All three are parameters.

Top module: `hiccup_guard`

## Requirements
- R1: While `ss_done` is low, current-limit cycles are not counted. Counting is enabled from the clock after `ss_done` is sampled high, and only while the block is not in hiccup.
- R2: Each `cyc_tick` with `ilim_hit` high, while counting is enabled, adds one to the overload count.
- R3: The tick that brings the overload count to FAULT_LIMIT sets `hiccup`=1, `sw_en`=0 and `ss_pull`=1 from the next clock on.
- R4: CLEAN_RUN consecutive counted ticks with `ilim_hit` low clear the overload count.
- R5: An overloaded tick restarts the clean run from zero. It does not reduce the overload count, so overloaded cycles separated by clean runs shorter than CLEAN_RUN accumulate.
- R6: Hiccup lasts for exactly OFF_CYCLES ticks after the tripping tick. After the last of these ticks, `hiccup`=0, `sw_en`=1 and `ss_pull`=0.
- R7: During hiccup `ilim_hit` has no effect. After the restart the overload count starts again from zero.
- R8: A synchronous active-high `rst` clears all counts and sets `hiccup`=0, `ss_pull`=0 and `sw_en`=1. It also treats soft-start as not completed.
- R9: Clocks without `cyc_tick` change no count and no output, whatever `ilim_hit` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_tick | input | 1 | One-clock strobe per PWM cycle |
| ilim_hit | input | 1 | Current limit tripped in this PWM cycle, sampled with `cyc_tick` |
| ss_done | input | 1 | Soft-start ramp has completed |
| sw_en | output | 1 | Switching allowed |
| ss_pull | output | 1 | Request to discharge the soft-start node |
| hiccup | output | 1 | Hiccup off period in progress |

## Verification
The bench sweeps how many overloaded ticks come before a clean run and how long that run is. It then measures how many further overloaded ticks are needed to trip. A design that cleared the count on any single clean cycle, or one that never cleared it, gives the wrong trip count for one of these pairs. The off period is measured tick by tick, which exposes an off-by-one in the off timer. The bench floods `ilim_hit` without ticks, during soft-start and during hiccup, to catch a design that counts in any of those states. It also checks that a restart begins with a fresh count rather than carrying over the old one.

// File: rtl/hiccup_guard.sv
module hiccup_guard #(
  parameter int FAULT_LIMIT = 64,
  parameter int CLEAN_RUN   = 8,
  parameter int OFF_CYCLES  = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_tick,
  input  logic ilim_hit,
  input  logic ss_done,
  output logic sw_en,
  output logic ss_pull,
  output logic hiccup
);
  localparam int FW = $clog2(FAULT_LIMIT);
  localparam int CW = $clog2(CLEAN_RUN);
  localparam int OW = $clog2(OFF_CYCLES);

  logic [FW-1:0] fault_cnt;
  logic [CW-1:0] clean_cnt;
  logic [OW-1:0] off_cnt;
  logic          ss_ok;
  logic          off_q;

  wire armed      = ss_ok & ~off_q;
  wire count_tick = cyc_tick & armed;
  wire bad_tick   = count_tick & ilim_hit;
  wire good_tick  = count_tick & ~ilim_hit;
  wire trip       = bad_tick & (fault_cnt == FW'(FAULT_LIMIT - 1));
  wire clean_full = good_tick & (clean_cnt == CW'(CLEAN_RUN - 1));
  wire off_done   = off_q & cyc_tick & (off_cnt == OW'(OFF_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_ok     <= 1'b0;
      off_q     <= 1'b0;
      fault_cnt <= '0;
      clean_cnt <= '0;
      off_cnt   <= '0;
    end else begin
      ss_ok <= ss_done & ~off_q & ~trip;

      if (!armed || trip || clean_full)
        fault_cnt <= '0;
      else if (bad_tick)
        fault_cnt <= fault_cnt + FW'(1);

      if (!armed || clean_full || bad_tick)
        clean_cnt <= '0;
      else if (good_tick)
        clean_cnt <= clean_cnt + CW'(1);

      if (trip)
        off_q <= 1'b1;
      else if (off_done)
        off_q <= 1'b0;

      if (!off_q || off_done)
        off_cnt <= '0;
      else if (cyc_tick)
        off_cnt <= off_cnt + OW'(1);
    end
  end

  assign hiccup  = off_q;
  assign ss_pull = off_q;
  assign sw_en   = ~off_q;
endmodule

// File: rtl/hiccup_guard_chk.sv
module hiccup_guard_chk #(
  parameter int FAULT_LIMIT = 64,
  parameter int CLEAN_RUN   = 8,
  parameter int OFF_CYCLES  = 32768
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            cyc_tick,
  input logic                            ilim_hit,
  input logic                            ss_done,
  input logic                            sw_en,
  input logic                            ss_pull,
  input logic                            hiccup,
  input logic [$clog2(FAULT_LIMIT)-1:0]  fault_cnt,
  input logic [$clog2(CLEAN_RUN)-1:0]    clean_cnt,
  input logic [$clog2(OFF_CYCLES)-1:0]   off_cnt
);
  a_r1_gated_by_softstart: assert property (@(posedge clk) disable iff (rst)
    !ss_done |-> ##2 (fault_cnt == '0));

  a_r3_trip_on_overload_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(hiccup) |-> $past(cyc_tick && ilim_hit));

  a_r3_outputs_agree: assert property (@(posedge clk) disable iff (rst)
    (sw_en == !hiccup) && (ss_pull == hiccup));

  a_r4_counts_in_range: assert property (@(posedge clk) disable iff (rst)
    (int'(fault_cnt) < FAULT_LIMIT) && (int'(clean_cnt) < CLEAN_RUN)
      && (int'(off_cnt) < OFF_CYCLES));

  a_r6_release_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(hiccup) |-> $past(cyc_tick));

  a_r7_idle_counts_in_hiccup: assert property (@(posedge clk) disable iff (rst)
    hiccup |-> (fault_cnt == '0 && clean_cnt == '0));

  a_r8_reset_state: assert property (@(posedge clk)
    rst |=> (!hiccup && sw_en && !ss_pull));

  a_r9_quiet_without_tick: assert property (@(posedge clk) disable iff (rst)
    !cyc_tick |=> ($stable(hiccup) && $stable(fault_cnt) || $past(!ss_done) || $past(!hiccup && fault_cnt == '0)));
endmodule

bind hiccup_guard hiccup_guard_chk #(
  .FAULT_LIMIT(FAULT_LIMIT),
  .CLEAN_RUN  (CLEAN_RUN),
  .OFF_CYCLES (OFF_CYCLES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cyc_tick (cyc_tick),
  .ilim_hit (ilim_hit),
  .ss_done  (ss_done),
  .sw_en    (sw_en),
  .ss_pull  (ss_pull),
  .hiccup   (hiccup),
  .fault_cnt(fault_cnt),
  .clean_cnt(clean_cnt),
  .off_cnt  (off_cnt)
);

// File: tb/hiccup_guard_tb.sv
module hiccup_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int F = 4;
  localparam int C = 3;
  localparam int O = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_tick = 1'b0;
  logic ilim_hit = 1'b0;
  logic ss_done = 1'b0;
  logic sw_en, ss_pull, hiccup;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  hiccup_guard #(.FAULT_LIMIT(F), .CLEAN_RUN(C), .OFF_CYCLES(O)) u_dut (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .ilim_hit(ilim_hit),
    .ss_done(ss_done), .sw_en(sw_en), .ss_pull(ss_pull), .hiccup(hiccup)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_outs(input int exp_hic, input string tag);
    check(int'({hiccup, ss_pull, sw_en}), exp_hic ? 6 : 1, tag);
  endtask

  task automatic tick(input logic ilim);
    @(negedge clk);
    cyc_tick = 1'b1;
    ilim_hit = ilim;
    @(negedge clk);
    cyc_tick = 1'b0;
    ilim_hit = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ss_done = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk);
    ss_done = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic trips_needed(output int n);
    n = 0;
    while (!hiccup && n < F + 3) begin
      tick(1'b1);
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();
    @(negedge clk);
    check_outs(0, "R8 reset state");

    // R1: overload ignored while soft-start incomplete
    repeat (3 * F) tick(1'b1);
    check_outs(0, "R1 no trip during soft-start");
    arm();
    trips_needed(n);
    check(n, F, "R1 fresh count after soft-start");
    check_outs(1, "R3 outputs in hiccup");

    // R6/R7: off period length, overload ignored during it
    repeat (O - 1) tick(1'b1);
    check_outs(1, "R6 still off one tick before end");
    tick(1'b1);
    check_outs(0, "R6 released after off period");
    trips_needed(n);
    check(n, F, "R7 fresh count after restart");

    // R9: clocks without tick
    do_reset();
    arm();
    repeat (F - 1) tick(1'b1);
    @(negedge clk);
    ilim_hit = 1'b1;
    repeat (6) @(negedge clk);
    ilim_hit = 1'b0;
    check_outs(0, "R9 no count without tick");
    tick(1'b1);
    check_outs(1, "R9 count retained across idle clocks");

    // R2/R5: interleaved overload accumulates
    do_reset();
    arm();
    for (int i = 0; i < F - 1; i++) begin
      tick(1'b1);
      repeat (C - 1) tick(1'b0);
    end
    check_outs(0, "R5 interleaved below limit");
    tick(1'b1);
    check_outs(1, "R2 interleaved reaches limit");

    // R4/R5 sweep over prefix length and clean-run length
    for (int p = 1; p < F; p++) begin
      for (int k = 0; k <= C + 1; k++) begin
        do_reset();
        arm();
        repeat (p) tick(1'b1);
        repeat (k) tick(1'b0);
        trips_needed(n);
        check(n, (k >= C) ? F : F - p, $sformatf("R4 R5 sweep p=%0d k=%0d", p, k));
      end
    end

    // R8: reset during hiccup
    do_reset();
    arm();
    repeat (F) tick(1'b1);
    check_outs(1, "R3 trip before reset");
    do_reset();
    @(negedge clk);
    check_outs(0, "R8 reset clears hiccup");
    repeat (2 * F) tick(1'b1);
    check_outs(0, "R8 soft-start not done after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule